// File: doc/BRIEF.md
# Cross-Clock Mailbox Register With Mail Flag

This block is a single-word message register that sits beside a FIFO and lets one agent hand a word to another without going through the queue. The sending agent runs on `wclk` and the receiving agent runs on `rclk`. The two clocks are independent. An active-low flag, `mail_flag_n`, goes low as soon as a word is posted. While it is low, further posts are refused, so an unread word can never be overwritten. When the receiver reads with its mailbox select high, the flag is released. It returns high on the sender's clock a few cycles later.

The receive port shares its data output with the FIFO. When the output is enabled, the mailbox select chooses between the held mail word and the FIFO output-register word. Two resets act on the mailbox. The full reset empties it and clears the held word. The partial reset empties it but keeps the held word. Both resets are synchronous and active low. They must be held low across at least three edges of each clock.

Each direction of the handshake is a toggle that crosses into the other clock through a two-flop synchronizer. The sender keeps one toggle and the receiver keeps one toggle. The word is pending while the two toggles differ.

Top module: `mbx_mailbox`

## Requirements
- R1: A `wclk` rising edge with `wr_sel`, `wr_en` high and `mail_flag_n` high stores `wr_data` and drives `mail_flag_n` low after that edge.
- R2: While `mail_flag_n` is low, a write attempt is refused: the held word and the flag stay as they were.
- R3: An `rclk` rising edge with `rd_sel` and `rd_en` high, taken while a word is pending on the read side, returns `mail_flag_n` high within four `wclk` cycles.
- R4: With `rd_oe` high, `rd_dout` equals the held mail word when `rd_sel` is 1 and `fifo_q` when `rd_sel` is 0. With `rd_oe` low, `rd_dout` is all zeros.
- R5: A full reset (`mst_rst_n` low) forces `mail_flag_n` high and clears the held word to zero.
- R6: A partial reset (`prt_rst_n` low) forces `mail_flag_n` high and keeps the held word.
- R7: The held word changes only on an accepted write. A cycle with `wr_en` or `wr_sel` low changes neither the word nor the flag.
- R8: A read with `rd_sel` high while no word is pending leaves `mail_flag_n` high and returns the same held word.
- R9: After the flag has returned high, a new write is accepted and replaces the held word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Sender clock |
| rclk | input | 1 | Receiver clock |
| mst_rst_n | input | 1 | Full reset, active low, synchronous in both domains |
| prt_rst_n | input | 1 | Partial reset, active low, keeps the held word |
| wr_sel | input | 1 | Sender selects the mailbox |
| wr_en | input | 1 | Sender write enable |
| wr_data | input | 36 | Word to post |
| rd_sel | input | 1 | Receiver selects mailbox (1) or FIFO (0) |
| rd_en | input | 1 | Receiver read enable |
| rd_oe | input | 1 | Receive output enable |
| fifo_q | input | 36 | FIFO output-register word |
| rd_dout | output | 36 | Receive data output |
| mail_flag_n | output | 1 | Low while mail is unread, on `wclk` |

## Verification
The bench runs sixteen post/read rounds. Each round uses a different arithmetic bit pattern, so a held word that is stuck, shifted or stale cannot match the expected value. Each round also tries a blocked post and a FIFO-routed read with a complementary word, which separates the two mux legs and catches an overwrite of unread mail. It also makes a second, redundant mailbox read, which separates a pending-gated release from one that fires on every select. Idle cycles with only one write control high, and both resets taken while mail is pending, separate data retention from clearing.

// File: rtl/mbx_pkg.sv
// Package: shared width and the receive-source encoding for the mailbox.
package mbx_pkg;
    parameter int MBX_DW = 36;

    typedef enum logic [1:0] {
        SRC_OFF  = 2'd0,
        SRC_FIFO = 2'd1,
        SRC_MAIL = 2'd2
    } rd_src_e;
endpackage

// File: rtl/mbx_sync.sv
// mbx_sync: multi-flop synchronizer for a single toggle signal.
// Assumes the input changes at most once per several destination cycles.
module mbx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain_q;

    // Shift the asynchronous toggle through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], d};
    end

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/mbx_wr_port.sv
// mbx_wr_port: sender side. It holds the mail word and the post toggle, and
// computes the flag from the post toggle and the synchronized release toggle.
// Assumes the release toggle is already synchronized into clk.
module mbx_wr_port #(
    parameter int DW = 36
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr_n,
    input  logic          sel,
    input  logic          en,
    input  logic [DW-1:0] din,
    input  logic          ack_sync,
    output logic          post_tgl,
    output logic [DW-1:0] word_q,
    output logic          flag_n
);
    logic accept;

    assign flag_n = (post_tgl == ack_sync);
    assign accept = sel && en && flag_n;

    // Flip the post toggle on every accepted write.
    always_ff @(posedge clk) begin
        if (!rst_n)      post_tgl <= 1'b0;
        else if (accept) post_tgl <= ~post_tgl;
    end

    // Hold the word; cleared only by a full reset.
    always_ff @(posedge clk) begin
        if (!clr_n)      word_q <= '0;
        else if (accept) word_q <= din;
    end

    // R1: an accepted write empties nothing and raises pending at once
    a_r1_post_lowers_flag: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !flag_n);

    // R2: a refused write keeps the held word
    a_r2_blocked_keeps_word: assert property (@(posedge clk) disable iff (!clr_n)
        (sel && en && !flag_n) |=> $stable(word_q));

    // R7: the word moves only on an accepted write
    a_r7_word_only_on_accept: assert property (@(posedge clk) disable iff (!clr_n)
        (!(sel && en)) |=> $stable(word_q));
endmodule

// File: rtl/mbx_rd_port.sv
// mbx_rd_port: receiver side. It flips the release toggle when a mailbox read
// finds mail pending. Assumes the post toggle is already synchronized into clk.
module mbx_rd_port (
    input  logic clk,
    input  logic rst_n,
    input  logic sel,
    input  logic en,
    input  logic post_sync,
    output logic ack_tgl,
    output logic pending
);
    logic take;

    assign pending = (post_sync != ack_tgl);
    assign take    = sel && en && pending;

    // Flip the release toggle on a mailbox read of pending mail.
    always_ff @(posedge clk) begin
        if (!rst_n)    ack_tgl <= 1'b0;
        else if (take) ack_tgl <= ~ack_tgl;
    end

    // R3: a mailbox read of pending mail clears pending on the read side
    a_r3_read_releases: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> !pending);

    // R8: a read with nothing pending leaves the release toggle alone
    a_r8_idle_read_no_release: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && en && !pending) |=> $stable(ack_tgl));
endmodule

// File: rtl/mbx_mailbox.sv
// mbx_mailbox: a cross-clock mailbox register with an active-low mail flag and
// a receive mux against FIFO data. Assumes both resets are held low across at
// least three edges of each clock.
module mbx_mailbox
    import mbx_pkg::*;
#(
    parameter int DW       = MBX_DW,
    parameter int SYNC_STG = 2
) (
    input  logic          wclk,
    input  logic          rclk,
    input  logic          mst_rst_n,
    input  logic          prt_rst_n,
    input  logic          wr_sel,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_sel,
    input  logic          rd_en,
    input  logic          rd_oe,
    input  logic [DW-1:0] fifo_q,
    output logic [DW-1:0] rd_dout,
    output logic          mail_flag_n
);
    logic          any_rst_n;
    logic          post_tgl, post_sync;
    logic          ack_tgl, ack_sync;
    logic          pending;
    logic [DW-1:0] word_q;
    rd_src_e       src;

    assign any_rst_n = mst_rst_n && prt_rst_n;

    mbx_wr_port #(.DW(DW)) u_wr (
        .clk(wclk), .rst_n(any_rst_n), .clr_n(mst_rst_n),
        .sel(wr_sel), .en(wr_en), .din(wr_data),
        .ack_sync(ack_sync), .post_tgl(post_tgl),
        .word_q(word_q), .flag_n(mail_flag_n)
    );

    mbx_sync #(.STAGES(SYNC_STG)) u_ack_sync (
        .clk(wclk), .rst_n(any_rst_n), .d(ack_tgl), .q(ack_sync)
    );

    mbx_sync #(.STAGES(SYNC_STG)) u_post_sync (
        .clk(rclk), .rst_n(any_rst_n), .d(post_tgl), .q(post_sync)
    );

    mbx_rd_port u_rd (
        .clk(rclk), .rst_n(any_rst_n), .sel(rd_sel), .en(rd_en),
        .post_sync(post_sync), .ack_tgl(ack_tgl), .pending(pending)
    );

    // Pick the receive source from the enable and the select.
    always_comb begin
        if (!rd_oe)      src = SRC_OFF;
        else if (rd_sel) src = SRC_MAIL;
        else             src = SRC_FIFO;
    end

    // Drive the receive bus from the chosen source.
    always_comb begin
        case (src)
            SRC_MAIL: rd_dout = word_q;
            SRC_FIFO: rd_dout = fifo_q;
            default:  rd_dout = '0;
        endcase
    end

    // R5 and R6: either reset leaves the flag high on the next edge
    a_r5_r6_reset_flag_high: assert property (@(posedge wclk)
        (!mst_rst_n || !prt_rst_n) |=> mail_flag_n);

    // R5: a full reset clears the word
    a_r5_master_clears_word: assert property (@(posedge wclk)
        (!mst_rst_n) |=> (word_q == '0));
endmodule

// File: tb/mbx_mailbox_tb.sv
`timescale 1ns/1ps
module mbx_mailbox_tb;
    localparam int DW = 36;

    logic          wclk = 1'b0, rclk = 1'b0;
    logic          mst_rst_n = 1'b0, prt_rst_n = 1'b1;
    logic          wr_sel = 1'b0, wr_en = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic          rd_sel = 1'b0, rd_en = 1'b0, rd_oe = 1'b1;
    logic [DW-1:0] fifo_q = '0;
    logic [DW-1:0] rd_dout;
    logic          mail_flag_n;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #2.5 wclk = ~wclk;
    always #4   rclk = ~rclk;

    mbx_mailbox u_dut (
        .wclk(wclk), .rclk(rclk), .mst_rst_n(mst_rst_n), .prt_rst_n(prt_rst_n),
        .wr_sel(wr_sel), .wr_en(wr_en), .wr_data(wr_data),
        .rd_sel(rd_sel), .rd_en(rd_en), .rd_oe(rd_oe), .fifo_q(fifo_q),
        .rd_dout(rd_dout), .mail_flag_n(mail_flag_n)
    );

    task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic s, input logic e, input logic [DW-1:0] d);
        @(negedge wclk);
        wr_sel = s; wr_en = e; wr_data = d;
        @(negedge wclk);
        wr_sel = 1'b0; wr_en = 1'b0;
    endtask

    task automatic do_read();
        @(negedge rclk);
        rd_sel = 1'b1; rd_en = 1'b1;
        @(negedge rclk);
        rd_en = 1'b0;
    endtask

    task automatic wait_r(input int n);
        for (int i = 0; i < n; i++) @(negedge rclk);
    endtask

    // Poll the flag for up to four wclk cycles; return 1 if it went high.
    task automatic flag_rise(output bit seen);
        seen = 1'b0;
        for (int i = 0; i < 4; i++) begin
            @(negedge wclk);
            if (mail_flag_n) seen = 1'b1;
        end
    endtask

    task automatic apply_reset(input bit full);
        @(negedge wclk);
        if (full) mst_rst_n = 1'b0; else prt_rst_n = 1'b0;
        wait_r(5);
        @(negedge wclk);
        mst_rst_n = 1'b1; prt_rst_n = 1'b1;
        wait_r(2);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [DW-1:0] pat;
        bit seen;
        wait_r(5);
        @(negedge wclk);
        mst_rst_n = 1'b1;
        wait_r(2);
        rd_sel = 1'b1;
        @(negedge wclk);
        chk("R5 reset flag", {35'd0, mail_flag_n}, 36'd1);
        chk("R5 reset word", rd_dout, '0);

        for (int k = 0; k < 16; k++) begin
            pat = DW'(64'h9E37_79B9_7F4A_7C15 * (k + 1)) ^ (DW'(1) << (k * 2));
            // R7: lone enable or lone select does nothing
            do_write(1'b0, 1'b1, ~pat);
            do_write(1'b1, 1'b0, ~pat);
            chk("R7 idle flag", {35'd0, mail_flag_n}, 36'd1);
            // R1 / R9: accepted write
            do_write(1'b1, 1'b1, pat);
            chk("R1 flag low", {35'd0, mail_flag_n}, 36'd0);
            // R2: refused overwrite
            do_write(1'b1, 1'b1, ~pat);
            chk("R2 flag still low", {35'd0, mail_flag_n}, 36'd0);
            wait_r(4);
            rd_sel = 1'b1; rd_oe = 1'b1;
            @(negedge rclk);
            chk("R2 R9 word kept", rd_dout, pat);
            // R4: mux legs
            fifo_q = ~pat; rd_sel = 1'b0;
            @(negedge rclk);
            chk("R4 fifo leg", rd_dout, ~pat);
            rd_oe = 1'b0;
            @(negedge rclk);
            chk("R4 output off", rd_dout, '0);
            rd_oe = 1'b1;
            // R3: release
            do_read();
            flag_rise(seen);
            chk("R3 flag high bound", {35'd0, seen}, 36'd1);
            // R8: redundant read
            do_read();
            wait_r(2);
            chk("R8 flag stays high", {35'd0, mail_flag_n}, 36'd1);
            chk("R8 stale word", rd_dout, pat);
        end

        // R6: partial reset with mail pending keeps the word
        pat = 36'hA_5A5A_0F0F;
        do_write(1'b1, 1'b1, pat);
        apply_reset(1'b0);
        rd_sel = 1'b1;
        @(negedge wclk);
        chk("R6 flag high", {35'd0, mail_flag_n}, 36'd1);
        chk("R6 word kept", rd_dout, pat);

        // R5: full reset with mail pending clears the word
        do_write(1'b1, 1'b1, ~pat);
        chk("R1 flag low after reset", {35'd0, mail_flag_n}, 36'd0);
        apply_reset(1'b1);
        @(negedge wclk);
        chk("R5 flag high", {35'd0, mail_flag_n}, 36'd1);
        chk("R5 word cleared", rd_dout, '0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule